// File: doc/BRIEF.md
# PLL Divider Search Engine

The block looks for the PLL divider setting whose output dot clock lands closest to a requested frequency. A start pulse samples a target frequency, a reference frequency (both in kHz) and a profile select. The profile select chooses between a serial DAC profile and an LVDS profile. The engine then visits every combination of input divider n, feedback sub-dividers m1 and m2, and first post divider p1. For each one it works out the VCO and dot frequencies with integer division. It drops any combination that breaks a legality window and keeps the closest survivor.

The effective feedback divider is m = 5·(m1+2) + (m2+2), and the effective input divider is n+2. The post divider is p = p1·p2. The second stage p2 is fixed for the whole search: the profile and a target-frequency threshold pick it. When the search ends, done pulses for one cycle. At that point the chosen dividers, the achieved dot clock, a found flag and two packed register words are presented, and they are held until the next accepted start. One shared multi-cycle divider carries out both divisions.

Top module: `pll_div_search`

## Requirements
- R1: For the reported setting, dot_o equals floor(floor(ref·m/(n+2)) / (p1·p2)), with m = 5·(m1+2)+(m2+2).
- R2: A setting is legal only if m1 > m2, n is in 1..6, m1 in 8..18, m2 in 3..7, p1 in 1..8, m in 70..120, VCO in 1,400,000..2,800,000 kHz and dot in 20,000..400,000 kHz.
- R3: With prof_lvds_i = 0, p1·p2 must be in 5..80, and p2 is 10 when the target is below 200,000 kHz and 5 otherwise.
- R4: With prof_lvds_i = 1, p1·p2 must be in 7..98, and p2 is 14 when the target is below 112,000 kHz and 7 otherwise.
- R5: The reported setting has the smallest |dot − target| among legal settings. On a tie, the first one visited wins. The visiting order is m1 ascending (outermost), then m2, then n, then p1 (innermost).
- R6: found_o is 1 exactly when at least one legal setting exists. When it is 0, all divider outputs, dot_o and both words are 0.
- R7: fp_word_o holds n in bits 23:16, m1 in bits 15:8 and m2 in bits 7:0, with the upper bits at 0.
- R8: ctl_word_o has bit 15+p1 set as a one-hot p1 code across bits 23:16. Bits 25:24 carry the p2 code (5→0, 7→1, 10→2, 14→3). Bit 26 is set for the LVDS profile. All other bits are 0.
- R9: done_o is high for exactly one cycle per search, and all result outputs stay constant from that cycle until the next accepted start.
- R10: A start pulse while a search is running is ignored. Input changes after the accepted start do not affect the result.
- R11: After reset, done_o and found_o are 0 and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken when idle |
| target_i | input | TGT_W (20) | Target dot clock, kHz |
| ref_i | input | REF_W (17) | Reference clock, kHz |
| prof_lvds_i | input | 1 | 1 selects the LVDS profile, 0 the serial DAC profile |
| done_o | output | 1 | One-cycle end-of-search pulse |
| found_o | output | 1 | A legal setting was found |
| n_o | output | 8 | Chosen input divider |
| m1_o | output | 8 | Chosen m1 |
| m2_o | output | 8 | Chosen m2 |
| p1_o | output | 8 | Chosen p1 |
| p2_o | output | 8 | Chosen p2 |
| dot_o | output | FRQ_W (24) | Achieved dot clock, kHz |
| fp_word_o | output | 32 | Packed divisor word |
| ctl_word_o | output | 32 | Packed control word |

## Verification
Targets just below and at each profile's threshold show whether p2 and the post-divider window switch at the right value. A mid-range target with the usual reference exercises the closest-match and first-found tie rule against a full software search. A reference too low for any VCO to reach its window separates the not-found path, with its zeroed outputs, from a merely poor match. Random targets, references and profiles spread the check over many error ties. A restart pulse with changed inputs during a running search shows whether the sampled inputs are really frozen.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
  localparam int unsigned FLD_W = 8;
  typedef logic [FLD_W-1:0] fld_t;

  typedef enum logic [2:0] {
    S_IDLE, S_CAND, S_VCO, S_DOT_ISSUE, S_DOT, S_NEXT, S_DONE
  } state_e;

  function automatic logic [1:0] p2_code(input fld_t p2);
    case (p2)
      8'd7:    return 2'd1;
      8'd10:   return 2'd2;
      8'd14:   return 2'd3;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/pll_div_seq.sv
module pll_div_seq #(
  parameter int unsigned W   = 24,
  parameter int unsigned BPC = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic         done_o,
  output logic [W-1:0] quo_o
);
  localparam int unsigned NCYC = W / BPC;
  localparam int unsigned CW   = $clog2(NCYC + 1);

  logic [W:0]    rem_q, rem_n;
  logic [W-1:0]  quo_q, quo_n, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  // BPC restoring steps per cycle
  always_comb begin
    rem_n = rem_q;
    quo_n = quo_q;
    for (int k = 0; k < int'(BPC); k++) begin
      rem_n = {rem_n[W-1:0], quo_n[W-1]};
      quo_n = {quo_n[W-2:0], 1'b0};
      if (rem_n >= {1'b0, dvs_q}) begin
        rem_n    = rem_n - {1'b0, dvs_q};
        quo_n[0] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      rem_q  <= '0;
      quo_q  <= dvd_i;
      dvs_q  <= dvs_i;
      cnt_q  <= CW'(NCYC);
      done_q <= 1'b0;
    end else if (cnt_q != '0) begin
      rem_q  <= rem_n;
      quo_q  <= quo_n;
      cnt_q  <= cnt_q - CW'(1);
      done_q <= (cnt_q == CW'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;

  p_div_nonzero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> dvs_i != '0);
  p_div_done_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/pll_p2_sel.sv
module pll_p2_sel
  import pll_search_pkg::*;
#(
  parameter int unsigned TGT_W       = 20,
  parameter int unsigned DAC_THR     = 200000,
  parameter int unsigned DAC_P2_LO   = 10,
  parameter int unsigned DAC_P2_HI   = 5,
  parameter int unsigned DAC_P_MIN   = 5,
  parameter int unsigned DAC_P_MAX   = 80,
  parameter int unsigned LVDS_THR    = 112000,
  parameter int unsigned LVDS_P2_LO  = 14,
  parameter int unsigned LVDS_P2_HI  = 7,
  parameter int unsigned LVDS_P_MIN  = 7,
  parameter int unsigned LVDS_P_MAX  = 98
) (
  input  logic             lvds_i,
  input  logic [TGT_W-1:0] target_i,
  output fld_t             p2_o,
  output fld_t             p_min_o,
  output fld_t             p_max_o
);
  logic below_c;

  assign below_c = lvds_i ? (target_i < TGT_W'(LVDS_THR)) : (target_i < TGT_W'(DAC_THR));

  always_comb begin
    if (lvds_i) begin
      p2_o    = below_c ? fld_t'(LVDS_P2_LO) : fld_t'(LVDS_P2_HI);
      p_min_o = fld_t'(LVDS_P_MIN);
      p_max_o = fld_t'(LVDS_P_MAX);
    end else begin
      p2_o    = below_c ? fld_t'(DAC_P2_LO) : fld_t'(DAC_P2_HI);
      p_min_o = fld_t'(DAC_P_MIN);
      p_max_o = fld_t'(DAC_P_MAX);
    end
  end
endmodule

// File: rtl/pll_word_pack.sv
module pll_word_pack
  import pll_search_pkg::*;
#(
  parameter int unsigned P1_MAX = 8
) (
  input  logic        found_i,
  input  logic        lvds_i,
  input  fld_t        n_i,
  input  fld_t        m1_i,
  input  fld_t        m2_i,
  input  fld_t        p1_i,
  input  fld_t        p2_i,
  output logic [31:0] fp_o,
  output logic [31:0] ctl_o
);
  logic [P1_MAX-1:0] p1_hot;

  for (genvar i = 0; i < int'(P1_MAX); i++) begin : g_p1
    assign p1_hot[i] = found_i && (p1_i == fld_t'(i + 1));
  end

  assign fp_o = found_i ? {8'd0, n_i, m1_i, m2_i} : 32'd0;

  always_comb begin
    ctl_o = 32'd0;
    ctl_o[16 +: P1_MAX] = p1_hot;
    if (found_i) begin
      ctl_o[25:24] = p2_code(p2_i);
      ctl_o[26]    = lvds_i;
    end
  end
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pll_search_pkg::*;
#(
  parameter int unsigned REF_W   = 17,
  parameter int unsigned TGT_W   = 20,
  parameter int unsigned FRQ_W   = 24,
  parameter int unsigned DIV_BPC = 8,
  parameter int unsigned N_MIN   = 1,
  parameter int unsigned N_MAX   = 6,
  parameter int unsigned M_MIN   = 70,
  parameter int unsigned M_MAX   = 120,
  parameter int unsigned M1_MIN  = 8,
  parameter int unsigned M1_MAX  = 18,
  parameter int unsigned M2_MIN  = 3,
  parameter int unsigned M2_MAX  = 7,
  parameter int unsigned P1_MIN  = 1,
  parameter int unsigned P1_MAX  = 8,
  parameter int unsigned VCO_MIN = 1400000,
  parameter int unsigned VCO_MAX = 2800000,
  parameter int unsigned DOT_MIN = 20000,
  parameter int unsigned DOT_MAX = 400000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TGT_W-1:0] target_i,
  input  logic [REF_W-1:0] ref_i,
  input  logic             prof_lvds_i,
  output logic             done_o,
  output logic             found_o,
  output logic [7:0]       n_o,
  output logic [7:0]       m1_o,
  output logic [7:0]       m2_o,
  output logic [7:0]       p1_o,
  output logic [7:0]       p2_o,
  output logic [FRQ_W-1:0] dot_o,
  output logic [31:0]      fp_word_o,
  output logic [31:0]      ctl_word_o
);
  state_e            state_q;
  logic [TGT_W-1:0]  tgt_q;
  logic [REF_W-1:0]  ref_q;
  logic              lvds_q;
  fld_t              n_q, m1_q, m2_q, p1_q;
  logic [FRQ_W-1:0]  vco_q;
  logic              bv_q;
  fld_t              bn_q, bm1_q, bm2_q, bp1_q;
  logic [FRQ_W-1:0]  bdot_q, berr_q;
  logic              res_found_q, res_lvds_q, done_q;
  fld_t              res_n_q, res_m1_q, res_m2_q, res_p1_q, res_p2_q;
  logic [FRQ_W-1:0]  res_dot_q;

  fld_t              p2_c, pmin_c, pmax_c;
  logic [15:0]       m_c, p_c;
  logic [FRQ_W-1:0]  prod_c, tgt_c, err_c, quo_c;
  logic [FRQ_W-1:0]  div_dvd, div_dvs;
  logic              div_start, div_done, cand_ok, p_ok, vco_ok, dot_ok, better_c;

  pll_p2_sel #(.TGT_W(TGT_W)) u_p2 (
    .lvds_i(lvds_q), .target_i(tgt_q), .p2_o(p2_c), .p_min_o(pmin_c), .p_max_o(pmax_c)
  );

  assign m_c     = 16'd5 * (16'(m1_q) + 16'd2) + 16'(m2_q) + 16'd2;
  assign p_c     = 16'(p1_q) * 16'(p2_c);
  assign prod_c  = FRQ_W'(ref_q) * FRQ_W'(m_c);
  assign cand_ok = (m1_q > m2_q) && (m_c >= 16'(M_MIN)) && (m_c <= 16'(M_MAX));
  assign p_ok    = (p_c >= 16'(pmin_c)) && (p_c <= 16'(pmax_c));
  assign vco_ok  = (quo_c >= FRQ_W'(VCO_MIN)) && (quo_c <= FRQ_W'(VCO_MAX));
  assign dot_ok  = (quo_c >= FRQ_W'(DOT_MIN)) && (quo_c <= FRQ_W'(DOT_MAX));
  assign tgt_c   = FRQ_W'(tgt_q);
  assign err_c   = (quo_c >= tgt_c) ? quo_c - tgt_c : tgt_c - quo_c;
  assign better_c = dot_ok && (!bv_q || (err_c < berr_q));

  always_comb begin
    div_start = 1'b0;
    div_dvd   = prod_c;
    div_dvs   = FRQ_W'(n_q) + FRQ_W'(2);
    if (state_q == S_CAND) begin
      div_start = cand_ok;
    end else if (state_q == S_DOT_ISSUE) begin
      div_start = p_ok;
      div_dvd   = vco_q;
      div_dvs   = FRQ_W'(p_c);
    end
  end

  pll_div_seq #(.W(FRQ_W), .BPC(DIV_BPC)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(div_start),
    .dvd_i(div_dvd), .dvs_i(div_dvs), .done_o(div_done), .quo_o(quo_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      tgt_q <= '0; ref_q <= '0; lvds_q <= 1'b0;
      n_q <= '0; m1_q <= '0; m2_q <= '0; p1_q <= '0; vco_q <= '0;
      bv_q <= 1'b0; bn_q <= '0; bm1_q <= '0; bm2_q <= '0; bp1_q <= '0;
      bdot_q <= '0; berr_q <= '0;
      res_found_q <= 1'b0; res_lvds_q <= 1'b0; done_q <= 1'b0;
      res_n_q <= '0; res_m1_q <= '0; res_m2_q <= '0; res_p1_q <= '0; res_p2_q <= '0;
      res_dot_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: if (start_i) begin
          tgt_q  <= target_i;
          ref_q  <= ref_i;
          lvds_q <= prof_lvds_i;
          n_q    <= fld_t'(N_MIN);
          m1_q   <= fld_t'(M1_MIN);
          m2_q   <= fld_t'(M2_MIN);
          bv_q   <= 1'b0;
          bn_q <= '0; bm1_q <= '0; bm2_q <= '0; bp1_q <= '0;
          bdot_q <= '0; berr_q <= '0;
          state_q <= S_CAND;
        end
        S_CAND: state_q <= cand_ok ? S_VCO : S_NEXT;
        S_VCO: if (div_done) begin
          vco_q <= quo_c;
          p1_q  <= fld_t'(P1_MIN);
          state_q <= vco_ok ? S_DOT_ISSUE : S_NEXT;
        end
        S_DOT_ISSUE: begin
          if (p_ok) state_q <= S_DOT;
          else if (p1_q == fld_t'(P1_MAX)) state_q <= S_NEXT;
          else p1_q <= p1_q + fld_t'(1);
        end
        S_DOT: if (div_done) begin
          if (better_c) begin
            bv_q <= 1'b1;
            bn_q <= n_q; bm1_q <= m1_q; bm2_q <= m2_q; bp1_q <= p1_q;
            bdot_q <= quo_c; berr_q <= err_c;
          end
          if (p1_q == fld_t'(P1_MAX)) state_q <= S_NEXT;
          else begin
            p1_q <= p1_q + fld_t'(1);
            state_q <= S_DOT_ISSUE;
          end
        end
        S_NEXT: begin
          state_q <= S_CAND;
          if (n_q != fld_t'(N_MAX)) n_q <= n_q + fld_t'(1);
          else begin
            n_q <= fld_t'(N_MIN);
            if (m2_q != fld_t'(M2_MAX)) m2_q <= m2_q + fld_t'(1);
            else begin
              m2_q <= fld_t'(M2_MIN);
              if (m1_q != fld_t'(M1_MAX)) m1_q <= m1_q + fld_t'(1);
              else state_q <= S_DONE;
            end
          end
        end
        S_DONE: begin
          res_found_q <= bv_q;
          res_lvds_q  <= lvds_q & bv_q;
          res_n_q <= bn_q; res_m1_q <= bm1_q; res_m2_q <= bm2_q; res_p1_q <= bp1_q;
          res_p2_q  <= bv_q ? p2_c : '0;
          res_dot_q <= bdot_q;
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  pll_word_pack #(.P1_MAX(P1_MAX)) u_pack (
    .found_i(res_found_q), .lvds_i(res_lvds_q),
    .n_i(res_n_q), .m1_i(res_m1_q), .m2_i(res_m2_q), .p1_i(res_p1_q), .p2_i(res_p2_q),
    .fp_o(fp_word_o), .ctl_o(ctl_word_o)
  );

  assign done_o  = done_q;
  assign found_o = res_found_q;
  assign n_o     = res_n_q;
  assign m1_o    = res_m1_q;
  assign m2_o    = res_m2_q;
  assign p1_o    = res_p1_q;
  assign p2_o    = res_p2_q;
  assign dot_o   = res_dot_q;

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(dot_o) && $stable(found_o) && $stable(fp_word_o) && $stable(ctl_word_o));
  p_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> (dot_o >= FRQ_W'(DOT_MIN)) && (dot_o <= FRQ_W'(DOT_MAX)) && (m1_o > m2_o));
  p_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !found_o |-> (fp_word_o == 32'd0) && (ctl_word_o == 32'd0) && (dot_o == '0));
  p_p1_hot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> $countones(ctl_word_o[23:16]) == 1);
  p_dac_p2_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (found_o && !ctl_word_o[26]) |-> (p2_o == 8'd5) || (p2_o == 8'd10));
  p_lvds_p2_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (found_o && ctl_word_o[26]) |-> (p2_o == 8'd7) || (p2_o == 8'd14));
  p_div_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE) |-> !div_done || $past(state_q) != S_IDLE);
endmodule

// File: tb/pll_div_search_tb_top.sv
`timescale 1ns/1ps
module pll_div_search_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [19:0] target_i = '0;
  logic [16:0] ref_i = '0;
  logic        prof_lvds_i = 1'b0;
  logic        done_o, found_o;
  logic [7:0]  n_o, m1_o, m2_o, p1_o, p2_o;
  logic [23:0] dot_o;
  logic [31:0] fp_word_o, ctl_word_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit found; int n; int m1; int m2; int p1; int p2; int dot;
  } res_t;

  always #4 clk_i = ~clk_i;

  pll_div_search dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .target_i(target_i),
    .ref_i(ref_i), .prof_lvds_i(prof_lvds_i), .done_o(done_o), .found_o(found_o),
    .n_o(n_o), .m1_o(m1_o), .m2_o(m2_o), .p1_o(p1_o), .p2_o(p2_o), .dot_o(dot_o),
    .fp_word_o(fp_word_o), .ctl_word_o(ctl_word_o)
  );

  function automatic res_t model(input int tgt, input int rf, input bit lv);
    res_t r;
    int p2, pmin, pmax, best;
    r = '{0, 0, 0, 0, 0, 0, 0};
    best = 0;
    p2   = lv ? ((tgt < 112000) ? 14 : 7) : ((tgt < 200000) ? 10 : 5);
    pmin = lv ? 7 : 5;
    pmax = lv ? 98 : 80;
    for (int m1 = 8; m1 <= 18; m1++)
      for (int m2 = 3; m2 <= 7; m2++)
        for (int n = 1; n <= 6; n++) begin
          int m, vco;
          if (m1 <= m2) continue;
          m = 5 * (m1 + 2) + (m2 + 2);
          if (m < 70 || m > 120) continue;
          vco = (rf * m) / (n + 2);
          if (vco < 1400000 || vco > 2800000) continue;
          for (int p1 = 1; p1 <= 8; p1++) begin
            int p, dot, err;
            p = p1 * p2;
            if (p < pmin || p > pmax) continue;
            dot = vco / p;
            if (dot < 20000 || dot > 400000) continue;
            err = (dot >= tgt) ? dot - tgt : tgt - dot;
            if (!r.found || err < best) begin
              r = '{1, n, m1, m2, p1, p2, dot};
              best = err;
            end
          end
        end
    return r;
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic wait_done();
    int cnt = 0;
    while (!done_o && cnt < 40000) begin
      @(negedge clk_i);
      cnt++;
    end
    if (!done_o) begin
      checks++; errors++;
      $display("FAIL R9 done timeout: actual=0 expected=1");
      finish_run();
    end
  endtask

  task automatic compare(input string tag, input res_t e, input bit lv);
    longint fp, ctl, code;
    code = (e.p2 == 7) ? 1 : (e.p2 == 10) ? 2 : (e.p2 == 14) ? 3 : 0;
    fp   = e.found ? ((longint'(e.n) << 16) | (longint'(e.m1) << 8) | e.m2) : 0;
    ctl  = e.found ? ((longint'(1) << (15 + e.p1)) | (code << 24) | (longint'(lv) << 26)) : 0;
    check({tag, " R6"}, "found", found_o, e.found);
    check({tag, " R5"}, "n", n_o, e.n);
    check({tag, " R5"}, "m1", m1_o, e.m1);
    check({tag, " R5"}, "m2", m2_o, e.m2);
    check({tag, " R5"}, "p1", p1_o, e.p1);
    check({tag, lv ? " R4" : " R3"}, "p2", p2_o, e.p2);
    check({tag, " R1"}, "dot", dot_o, e.dot);
    check({tag, " R7"}, "fp_word", fp_word_o, fp);
    check({tag, " R8"}, "ctl_word", ctl_word_o, ctl);
  endtask

  task automatic search(input string tag, input int tgt, input int rf, input bit lv);
    res_t e;
    logic [23:0] dot_s;
    e = model(tgt, rf, lv);
    @(negedge clk_i);
    target_i = 20'(tgt); ref_i = 17'(rf); prof_lvds_i = lv; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_done();
    compare(tag, e, lv);
    if (e.found) check({tag, " R2"}, "m1>m2", longint'(m1_o > m2_o), 1);
    dot_s = dot_o;
    @(negedge clk_i);
    check({tag, " R9"}, "done width", done_o, 0);
    repeat (5) @(negedge clk_i);
    check({tag, " R9"}, "dot held", dot_o, dot_s);
  endtask

  initial begin
    repeat (195000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    res_t e;
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk_i);
    // R11 reset state
    check("R11", "done", done_o, 0);
    check("R11", "found", found_o, 0);
    check("R11", "fp_word", fp_word_o, 0);
    check("R11", "ctl_word", ctl_word_o, 0);
    check("R11", "dot", dot_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    search("mid dac", 108000, 96000, 1'b0);
    search("dac thr-1", 199999, 96000, 1'b0);
    search("dac thr", 200000, 96000, 1'b0);
    search("lvds thr-1", 111999, 96000, 1'b1);
    search("lvds thr", 112000, 96000, 1'b1);
    search("no-fit R6", 65000, 1000, 1'b0);
    check("R6", "p1_o zero", p1_o, 0);

    for (int i = 0; i < 2; i++) begin
      int t, r;
      bit l;
      t = 20000 + int'($urandom_range(380000));
      r = 48000 + int'($urandom_range(83071));
      l = 1'(($urandom >> 3) & 1);
      search("random", t, r, l);
    end

    // R10: restart attempt with changed inputs mid-search
    e = model(150000, 96000, 1'b0);
    @(negedge clk_i);
    target_i = 20'd150000; ref_i = 17'd96000; prof_lvds_i = 1'b0; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (40) @(negedge clk_i);
    target_i = 20'd330000; ref_i = 17'd120000; prof_lvds_i = 1'b1; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_done();
    compare("restart R10", e, 1'b0);

    finish_run();
  end
endmodule